// File: doc/BRIEF.md
# Configurable GPIO Port with Edge Wakeup

This block is a general-purpose I/O port for a small microcontroller core. Every pin has its own settings for direction, pull-up and Schmitt-trigger input, and can be armed as an edge-sensitive event source on a rising or a falling edge. Pads are modelled as three separate signal groups: the output value, the output enable and the sampled input. The pull-up and Schmitt settings are only driven out to the pad ring. Analog behaviour stays outside this block.

A read of the data address returns the level actually present on the pins, not the output latch. That level can optionally pass through a two-stage synchronizer. The bit-set and bit-clear operations work from this pin level. As a result, a pin held against its latch by an external load rewrites its own latch bit. Edge events collect in a pending register that software clears by writing ones. While the core sleeps, a pending event asserts a wakeup request. While the core is awake, the same event asserts an interrupt request.

The core reaches the port through a simple single-cycle register interface. Writes take effect on the clock edge where the write enable is sampled. The read data is combinational from the address.

Top module: `gpio_wake_port`

## Requirements
- R1: After reset, all configuration registers and the output latch are zero, every pin is undriven (`padOe` = 0, `padOut` = 0), and `wakeReq` and `irqReq` are low.
- R2: A write to address 1 sets the direction register, where bit value 1 drives the pin: `padOe` equals that register. A write to address 0 loads the output latch, which appears on `padOut`.
- R3: Address 2 holds the pull-up enables and address 3 holds the Schmitt enables. Each one drives its output port bit for bit and reads back unchanged.
- R4: A read of address 0 returns the observed pin level, even for a pin configured as output whose external level differs from the latch.
- R5: Bit 0 of address 9 enables the synchronizer. When it is set, a pin change becomes visible to a read after two clock edges. When it is clear, the change is visible after one edge.
- R6: A read of address 0 taken right after the edge that writes the output latch returns the previous pin level.
- R7: Address 4 enables pins as event sources. Address 5 selects the edge per pin: 0 means rising, 1 means falling. Only an enabled pin that sees its selected edge sets its bit in the pending register (address 6).
- R8: Writing ones to address 6 clears those pending bits. An edge detected in the same cycle as the clear keeps its bit set.
- R9: With any pending bit set, `wakeReq` is high while `sleeping` is high, and `irqReq` is high while `sleeping` is low. The other request stays low in each case.
- R10: A write to address 7 sets the latch to (pin level OR data). A write to address 8 sets the latch to (pin level AND NOT data). A pin held low from outside therefore clears its own latch bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| wrData | input | PIN_COUNT | Write data |
| rdData | output | PIN_COUNT | Read data for regAddr |
| sleeping | input | 1 | Core is in sleep mode |
| padIn | input | PIN_COUNT | Level seen at each pad |
| padOut | output | PIN_COUNT | Output latch to pads |
| padOe | output | PIN_COUNT | Output enable per pad |
| pullEn | output | PIN_COUNT | Pull-up enable per pad |
| schmittEn | output | PIN_COUNT | Schmitt input enable per pad |
| wakeReq | output | 1 | Wakeup request to sleeping core |
| irqReq | output | 1 | Interrupt request to awake core |

## Verification
The bench builds the port at its default width of eight pins. At that width a random mix of directions, latch values and external levels exercises every pin position in both directions and both synchronizer settings. The width also lets the tests hold one pin against its latch while its neighbours stay free, which makes the read-modify-write corruption and the pin-versus-latch readback visible on single bits. The edge tests use two armed pins with opposite edge selects next to an unarmed pin.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [3:0] {
    ADDR_DATA    = 4'd0,
    ADDR_DIR     = 4'd1,
    ADDR_PULL    = 4'd2,
    ADDR_SCHMITT = 4'd3,
    ADDR_WAKE    = 4'd4,
    ADDR_EDGE    = 4'd5,
    ADDR_PEND    = 4'd6,
    ADDR_SETBIT  = 4'd7,
    ADDR_CLRBIT  = 4'd8,
    ADDR_CFG     = 4'd9
  } regAddr_e;

  typedef struct packed {
    logic wrLatch;
    logic wrDir;
    logic wrPull;
    logic wrSchmitt;
    logic wrWake;
    logic wrEdge;
    logic clrPend;
    logic setBits;
    logic clrBits;
    logic wrCfg;
  } ctrlStb_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic       wrEn,
  input  logic [3:0] regAddr,
  output ctrlStb_t   stb
);

  always_comb begin
    stb = '0;
    if (wrEn) begin
      case (regAddr)
        ADDR_DATA:    stb.wrLatch   = 1'b1;
        ADDR_DIR:     stb.wrDir     = 1'b1;
        ADDR_PULL:    stb.wrPull    = 1'b1;
        ADDR_SCHMITT: stb.wrSchmitt = 1'b1;
        ADDR_WAKE:    stb.wrWake    = 1'b1;
        ADDR_EDGE:    stb.wrEdge    = 1'b1;
        ADDR_PEND:    stb.clrPend   = 1'b1;
        ADDR_SETBIT:  stb.setBits   = 1'b1;
        ADDR_CLRBIT:  stb.clrBits   = 1'b1;
        ADDR_CFG:     stb.wrCfg     = 1'b1;
        default:      stb = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStb_t             stb,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic [3:0]           regAddr,
  input  logic [PIN_COUNT-1:0] padIn,
  input  logic                 sleeping,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] pullEn,
  output logic [PIN_COUNT-1:0] schmittEn,
  output logic [PIN_COUNT-1:0] rdData,
  output logic                 wakeReq,
  output logic                 irqReq
);

  localparam int PW = PIN_COUNT;

  logic [PW-1:0] latchQ, dirQ, pullQ, schmittQ, wakeEnQ, edgeSelQ, pendQ;
  logic          syncEnQ;
  logic [PW-1:0] stage1Q, stage2Q, prevQ;
  logic [PW-1:0] pinView, edgeHit, clrMask;

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ     <= '0;
      pullQ    <= '0;
      schmittQ <= '0;
      wakeEnQ  <= '0;
      edgeSelQ <= '0;
      syncEnQ  <= 1'b0;
    end else begin
      if (stb.wrDir)     dirQ     <= wrData;
      if (stb.wrPull)    pullQ    <= wrData;
      if (stb.wrSchmitt) schmittQ <= wrData;
      if (stb.wrWake)    wakeEnQ  <= wrData;
      if (stb.wrEdge)    edgeSelQ <= wrData;
      if (stb.wrCfg)     syncEnQ  <= wrData[0];
    end
  end

  // Input sampling: one stage always, second stage when synchronizer is on
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Q <= '0;
      stage2Q <= '0;
      prevQ   <= '0;
    end else begin
      stage1Q <= padIn;
      stage2Q <= stage1Q;
      prevQ   <= pinView;
    end
  end

  assign pinView = syncEnQ ? stage2Q : stage1Q;

  // Output latch with read-modify-write from the observed pin level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
    end else if (stb.wrLatch) begin
      latchQ <= wrData;
    end else if (stb.setBits) begin
      latchQ <= pinView | wrData;
    end else if (stb.clrBits) begin
      latchQ <= pinView & ~wrData;
    end
  end

  // Per-pin edge detection
  for (genvar p = 0; p < PW; p++) begin : g_edge
    logic riseP, fallP;
    assign riseP      = pinView[p] & ~prevQ[p];
    assign fallP      = ~pinView[p] & prevQ[p];
    assign edgeHit[p] = wakeEnQ[p] & (edgeSelQ[p] ? fallP : riseP);
  end

  assign clrMask = stb.clrPend ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~clrMask) | edgeHit;
  end

  // Read mux
  always_comb begin
    case (regAddr)
      ADDR_DATA:    rdData = pinView;
      ADDR_DIR:     rdData = dirQ;
      ADDR_PULL:    rdData = pullQ;
      ADDR_SCHMITT: rdData = schmittQ;
      ADDR_WAKE:    rdData = wakeEnQ;
      ADDR_EDGE:    rdData = edgeSelQ;
      ADDR_PEND:    rdData = pendQ;
      ADDR_CFG:     rdData = {{(PW-1){1'b0}}, syncEnQ};
      default:      rdData = '0;
    endcase
  end

  assign padOut    = latchQ;
  assign padOe     = dirQ;
  assign pullEn    = pullQ;
  assign schmittEn = schmittQ;
  assign wakeReq   = sleeping & (|pendQ);
  assign irqReq    = ~sleeping & (|pendQ);

  assert_pend_needs_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((pendQ & ~$past(pendQ) & ~$past(wakeEnQ)) == '0));

  assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrPend && ((edgeHit & wrData) == '0)) |=> ((pendQ & $past(wrData)) == '0));

  assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrLatch || stb.setBits || stb.clrBits) |=> $stable(padOut));

  assert_set_bits_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.setBits |=> ((padOut & $past(wrData)) == $past(wrData)));

endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [3:0]           regAddr,
  input  logic [PIN_COUNT-1:0] wrData,
  output logic [PIN_COUNT-1:0] rdData,
  input  logic                 sleeping,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] pullEn,
  output logic [PIN_COUNT-1:0] schmittEn,
  output logic                 wakeReq,
  output logic                 irqReq
);

  ctrlStb_t stb;

  gpio_port_ctrl u_ctrl (
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .stb     (stb)
  );

  gpio_port_datapath #(.PIN_COUNT(PIN_COUNT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .regAddr   (regAddr),
    .padIn     (padIn),
    .sleeping  (sleeping),
    .padOut    (padOut),
    .padOe     (padOe),
    .pullEn    (pullEn),
    .schmittEn (schmittEn),
    .rdData    (rdData),
    .wakeReq   (wakeReq),
    .irqReq    (irqReq)
  );

endmodule

// File: tb/tb_gpio_wake_port.sv
module tb_gpio_wake_port;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [3:0]   regAddr = '0;
  logic [N-1:0] wrData = '0;
  logic [N-1:0] rdData;
  logic         sleeping = 1'b0;
  logic [N-1:0] padIn;
  logic [N-1:0] padOut, padOe, pullEn, schmittEn;
  logic         wakeReq, irqReq;

  // External world model
  logic [N-1:0] extVal = '0;
  logic [N-1:0] forceEn = '0;
  logic [N-1:0] forceVal = '0;

  // Bench shadows of what was written
  logic [N-1:0] dirS = '0;
  logic [N-1:0] latchS = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign padIn = (forceEn & forceVal) | (~forceEn & ((padOe & padOut) | (~padOe & extVal)));

  gpio_wake_port #(.PIN_COUNT(N)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .sleeping(sleeping), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .pullEn(pullEn), .schmittEn(schmittEn),
    .wakeReq(wakeReq), .irqReq(irqReq)
  );

  function automatic logic [N-1:0] expPin();
    return (forceEn & forceVal) | (~forceEn & ((dirS & latchS) | (~dirS & extVal)));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 4'd1) dirS = d;
    if (a == 4'd0) latchS = d;
  endtask

  task automatic rd(input logic [3:0] a, output logic [N-1:0] v);
    regAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    void'($urandom(32'd4242));
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 padOe", padOe, '0);
    chk("R1 padOut", padOut, '0);
    chk("R1 requests", {wakeReq, irqReq}, 2'b00);
    rd(4'd1, v); chk("R1 dir", v, '0);
    rd(4'd9, v); chk("R1 cfg", v, '0);

    // R3 pull-up and Schmitt
    wr(4'd2, 8'hA5);
    wr(4'd3, 8'h3C);
    chk("R3 pullEn", pullEn, 8'hA5);
    chk("R3 schmittEn", schmittEn, 8'h3C);
    rd(4'd2, v); chk("R3 pull rd", v, 8'hA5);
    rd(4'd3, v); chk("R3 schmitt rd", v, 8'h3C);

    // R6/R5 write-then-read latency, synchronizer off
    wr(4'd1, 8'hFF);
    wr(4'd0, 8'h00);
    tick(3);
    wr(4'd0, 8'h5A);
    rd(4'd0, v); chk("R6 nosync old level", v, 8'h00);
    tick(1);
    rd(4'd0, v); chk("R5 nosync one edge", v, 8'h5A);

    // R6/R5 synchronizer on
    wr(4'd9, 8'h01);
    tick(3);
    wr(4'd0, 8'hC3);
    rd(4'd0, v); chk("R6 sync old level", v, 8'h5A);
    tick(1);
    rd(4'd0, v); chk("R5 sync not after one edge", v, 8'h5A);
    tick(1);
    rd(4'd0, v); chk("R5 sync after two edges", v, 8'hC3);
    wr(4'd9, 8'h00);

    // R4 / R10 pin vs latch, read-modify-write
    wr(4'd0, 8'h0F);
    forceEn = 8'h02; forceVal = 8'h00;
    tick(3);
    rd(4'd0, v); chk("R4 read pin not latch", v, 8'h0D);
    chk("R4 latch unchanged", padOut, 8'h0F);
    wr(4'd7, 8'h80);
    chk("R10 setbit corrupts held pin", padOut, 8'h8D);
    forceEn = '0;
    latchS = 8'h8D;
    tick(3);
    wr(4'd8, 8'h01);
    chk("R10 clrbit", padOut, 8'h8C);
    latchS = 8'h8C;

    // R7 edges: pin0 rising, pin1 falling, pin2 not enabled
    wr(4'd1, 8'h00);
    extVal = 8'h02;
    tick(3);
    wr(4'd4, 8'h03);
    wr(4'd5, 8'h02);
    wr(4'd6, 8'hFF);
    rd(4'd6, v); chk("R8 pending cleared", v, 8'h00);
    extVal = 8'h05;
    tick(3);
    rd(4'd6, v); chk("R7 selected edges", v, 8'h03);

    // R9 request routing
    sleeping = 1'b1; #1;
    chk("R9 asleep", {wakeReq, irqReq}, 2'b10);
    sleeping = 1'b0; #1;
    chk("R9 awake", {wakeReq, irqReq}, 2'b01);

    // R8 partial clear
    wr(4'd6, 8'h01);
    rd(4'd6, v); chk("R8 w1c one bit", v, 8'h02);
    wr(4'd6, 8'h02);
    chk("R9 no request when clear", {wakeReq, irqReq}, 2'b00);

    // R7 opposite edges do not set pending
    extVal = 8'h02;
    tick(3);
    rd(4'd6, v); chk("R7 wrong edges ignored", v, 8'h00);

    // R8 edge coinciding with clear survives
    extVal = 8'h03;
    @(posedge clk);
    wr(4'd6, 8'h01);
    rd(4'd6, v); chk("R8 set wins over clear", v, 8'h01);
    wr(4'd6, 8'hFF);
    wr(4'd4, 8'h00);

    // Random mix: R2 and R4
    for (int i = 0; i < 40; i++) begin
      logic [N-1:0] d, l;
      d = N'($urandom);
      l = N'($urandom);
      extVal = N'($urandom);
      wr(4'd9, {7'd0, 1'($urandom)});
      wr(4'd1, d);
      wr(4'd0, l);
      tick(3);
      chk("R2 padOe", padOe, dirS);
      chk("R2 padOut", padOut, latchS);
      rd(4'd0, v); chk("R4 random read", v, expPin());
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule